// File: doc/BRIEF.md
# Ethernet receive frame classifier

This block sits behind a byte-wide gigabit PHY receive interface running full duplex. It finds each frame by its preamble and start-of-frame delimiter, makes sure the line was quiet long enough before it, and runs a CRC-32 over the frame. It then decides whether to keep the frame. A frame is kept when the CRC is correct, the length is legal, the destination matches, and the frame belongs to one of four protocol classes.

Kept frames go into a circular byte store. Each frame is preceded by a one-byte class tag, and the four CRC bytes are stripped. A frame becomes readable only after its last byte has been judged good. Reading then starts by itself at one byte per clock. There is no back-pressure toward the line or from the consumer.

Flow-control pause frames are never stored. Their quanta value is presented on a separate pulse output instead.

Top module: `rx_frame_classifier`

## Requirements
- R1: While reset is high and after it is released, with no frame received, `out_valid` and `pause_valid` are low.
- R2: A frame is accepted only if `rx_dv` was sampled low on at least IFG_MIN (default 12) consecutive clocks just before it rises. A frame that starts sooner is dropped entirely.
- R3: The frame opens with zero or more 0x55 bytes followed by 0xD5. Any other byte before 0xD5 drops the frame.
- R4: A frame is dropped when the CRC-32 fails. The CRC uses the reflected IEEE 802.3 polynomial with an all-ones preset, and runs over every byte after 0xD5 including the 4 FCS bytes. It must end at the residue 0xC704DD7B (normal bit order).
- R5: A non-pause frame is kept only if its destination (first six bytes; `local_mac[47:40]` is the first byte) is all ones or equals `local_mac`.
- R6: The length counts the bytes after 0xD5, including the FCS. A frame shorter than 64 bytes or longer than 1518 bytes is dropped.
- R7: The frame is classified from its type field (bytes 12–13) and tagged. 0x0806 gives tag 0x03 (ARP). 0x0800 with byte 23 equal to 6 gives 0x01 (TCP), 17 gives 0x02 (UDP), and 1 gives 0x04 (ICMP). Every other frame is dropped.
- R8: A kept frame is delivered as follows. First comes the tag byte with `out_sof` high. Then come the frame bytes from the first destination byte through the last byte before the FCS, with `out_eof` high on that last byte. Frames leave in arrival order, and no byte leaves that was not expected.
- R9: A pause frame has type 0x8808 and opcode bytes 14–15 equal to 0x0001. Its destination is 01-80-C2-00-00-01 or `local_mac`, its CRC is good, and its length is legal. For such a frame, `pause_valid` pulses for one clock, one clock after `rx_dv` is first sampled low. At the same time `pause_quanta` carries bytes 16–17 (byte 16 high). Nothing is stored.
- R10: A frame whose 0xD5 arrives while the store has fewer than 1515 free bytes is dropped whole. Later frames are unaffected.
- R11: Output starts without any request. With an empty store, the tag byte is valid 4 clocks after the last frame byte was sampled. The bytes of a frame then leave on consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| local_mac | input | 48 | Station address, first transmitted byte in bits 47:40 |
| rx_dv | input | 1 | Receive data valid from the PHY |
| rx_d | input | 8 | Receive byte from the PHY |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte (tag or frame byte) |
| out_sof | output | 1 | Marks the tag byte that opens a frame |
| out_eof | output | 1 | Marks the last byte of a frame |
| pause_valid | output | 1 | One-clock pulse for an accepted pause frame |
| pause_quanta | output | 16 | Quanta of the last accepted pause frame |

## Verification
Each wrong internal state of this block shows up at the ports within one frame.

- A write pointer left behind after a rollback surfaces as stray or missing bytes in the next delivered frame.
- A missed tag write shows as a wrong first byte.
- A stuck or wrong commit pointer shows either as nothing appearing 4 clocks after a good frame ends, or as a frame delivered with gaps.
- Errors in the gap counter, the preamble state or the length counter appear as a frame count that is off by one after the next frame.

The bench therefore compares every output byte and its marks against a queue it builds from the frames it sends. It also counts delivered frames after every case, and times both the first output byte and the pause pulse.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam logic [7:0]  TAG_TCP  = 8'h01;
  localparam logic [7:0]  TAG_UDP  = 8'h02;
  localparam logic [7:0]  TAG_ARP  = 8'h03;
  localparam logic [7:0]  TAG_ICMP = 8'h04;

  localparam logic [15:0] ET_IPV4  = 16'h0800;
  localparam logic [15:0] ET_ARP   = 16'h0806;
  localparam logic [15:0] ET_MACCT = 16'h8808;
  localparam logic [15:0] OP_PAUSE = 16'h0001;
  localparam logic [47:0] PAUSE_DA = 48'h0180_C200_0001;

  // residue written in normal bit order; the engine shifts LSB first
  localparam logic [31:0] CRC_RESIDUE = 32'hC704_DD7B;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_DATA, S_DROP, S_END1, S_END2} rx_state_e;

  function automatic logic [31:0] bitrev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 32'hEDB8_8320;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/rxc_crc32.sv
module rxc_crc32
  import rxc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  d,
  output logic [31:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '1;
    else if (en)    crc <= crc_step(crc, d);
  end
endmodule

// File: rtl/rxc_frame_buf.sv
module rxc_frame_buf #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [9:0]        wdata,
  input  logic [ADDR_W:0]   commit_ptr,
  output logic [ADDR_W:0]   rd_ptr,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_sof,
  output logic              out_eof
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [9:0] mem [0:DEPTH-1];
  logic [9:0] q;
  logic       rd_en;

  assign rd_en = (rd_ptr != commit_ptr);

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) q <= mem[rd_ptr[ADDR_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= rd_en;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign out_sof  = q[9];
  assign out_eof  = q[8];
  assign out_data = q[7:0];
endmodule

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier
  import rxc_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int MAX_LEN = 1518,
  parameter int MIN_LEN = 64,
  parameter int IFG_MIN = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [47:0] local_mac,
  input  logic        rx_dv,
  input  logic [7:0]  rx_d,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_sof,
  output logic        out_eof,
  output logic        pause_valid,
  output logic [15:0] pause_quanta
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(MAX_LEN + 1);
  localparam int GW    = $clog2(IFG_MIN + 1);
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(DEPTH);
  localparam logic [ADDR_W:0] NEED_V  = (ADDR_W+1)'(MAX_LEN - 3);
  localparam logic [31:0]     RESID_R = bitrev32(CRC_RESIDUE);

  rx_state_e        st;
  logic [GW-1:0]    gap_cnt;
  logic [CW-1:0]    cnt;
  logic [4:0][7:0]  pipe;
  logic [47:0]      dest;
  logic [15:0]      etype, opcode, quanta;
  logic [7:0]       ipproto;
  logic [ADDR_W:0]  wp, wstart, cp, rp;
  logic [31:0]      crc;

  logic             we;
  logic [ADDR_W-1:0] waddr;
  logic [9:0]       wdata;
  logic             gap_ok, take_byte, space_ok, fcs_ok, len_ok;
  logic             dest_keep, dest_pause, cls_ok, acc_frame, acc_pause;
  logic [7:0]       tag;

  assign gap_ok     = (gap_cnt == GW'(IFG_MIN));
  assign take_byte  = (st == S_DATA) && rx_dv && (cnt != CW'(MAX_LEN));
  assign space_ok   = (DEPTH_V - (wp - rp)) >= NEED_V;
  assign fcs_ok     = (crc == RESID_R);
  assign len_ok     = (cnt >= CW'(MIN_LEN));
  assign dest_keep  = (&dest) || (dest == local_mac);
  assign dest_pause = (dest == PAUSE_DA) || (dest == local_mac);

  always_comb begin
    cls_ok = 1'b1;
    tag    = TAG_ARP;
    if (etype == ET_ARP) tag = TAG_ARP;
    else if (etype == ET_IPV4) begin
      case (ipproto)
        8'd6:    tag = TAG_TCP;
        8'd17:   tag = TAG_UDP;
        8'd1:    tag = TAG_ICMP;
        default: cls_ok = 1'b0;
      endcase
    end else cls_ok = 1'b0;
  end

  assign acc_frame = fcs_ok && len_ok && dest_keep && cls_ok;
  assign acc_pause = fcs_ok && len_ok && dest_pause &&
                     (etype == ET_MACCT) && (opcode == OP_PAUSE);

  // single write port: payload bytes, then last byte with end mark, then the tag slot
  always_comb begin
    we    = 1'b0;
    waddr = wp[ADDR_W-1:0];
    wdata = {2'b00, pipe[4]};
    if (take_byte && cnt >= CW'(5)) we = 1'b1;
    else if (st == S_END1) begin
      we    = 1'b1;
      wdata = {2'b01, pipe[4]};
    end else if (st == S_END2) begin
      we    = 1'b1;
      waddr = wstart[ADDR_W-1:0];
      wdata = {2'b10, tag};
    end
  end

  rxc_crc32 u_crc (
    .clk (clk),
    .rst (rst),
    .clr (st != S_DATA),
    .en  (take_byte),
    .d   (rx_d),
    .crc (crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      gap_cnt      <= '0;
      cnt          <= '0;
      pipe         <= '0;
      dest         <= '0;
      etype        <= '0;
      opcode       <= '0;
      quanta       <= '0;
      ipproto      <= '0;
      wp           <= '0;
      wstart       <= '0;
      cp           <= '0;
      pause_valid  <= 1'b0;
      pause_quanta <= '0;
    end else begin
      pause_valid <= 1'b0;
      if (rx_dv)        gap_cnt <= '0;
      else if (!gap_ok) gap_cnt <= gap_cnt + 1'b1;

      if (take_byte) begin
        cnt  <= cnt + 1'b1;
        pipe <= {pipe[3:0], rx_d};
        if (cnt < CW'(6))                      dest    <= {dest[39:0], rx_d};
        if (cnt == CW'(12) || cnt == CW'(13))  etype   <= {etype[7:0], rx_d};
        if (cnt == CW'(14) || cnt == CW'(15))  opcode  <= {opcode[7:0], rx_d};
        if (cnt == CW'(16) || cnt == CW'(17))  quanta  <= {quanta[7:0], rx_d};
        if (cnt == CW'(23))                    ipproto <= rx_d;
        if (cnt >= CW'(5))                     wp      <= wp + 1'b1;
      end

      case (st)
        S_IDLE, S_PRE: begin
          if (rx_dv) begin
            if (st == S_IDLE && !gap_ok) st <= S_DROP;
            else if (rx_d == 8'h55)      st <= S_PRE;
            else if (rx_d == 8'hD5 && space_ok) begin
              st     <= S_DATA;
              cnt    <= '0;
              wstart <= wp;
              wp     <= wp + 1'b1;
            end else st <= S_DROP;
          end else st <= S_IDLE;
        end
        S_DATA: begin
          if (rx_dv) begin
            if (!take_byte) begin
              st <= S_DROP;
              wp <= wstart;
            end
          end else if (acc_frame) st <= S_END1;
          else begin
            st <= S_IDLE;
            wp <= wstart;
            if (acc_pause) begin
              pause_valid  <= 1'b1;
              pause_quanta <= quanta;
            end
          end
        end
        S_END1: begin
          wp <= wp + 1'b1;
          st <= S_END2;
        end
        S_END2: begin
          cp <= wp;
          st <= S_IDLE;
        end
        default: if (!rx_dv) st <= S_IDLE;
      endcase
    end
  end

  rxc_frame_buf #(.ADDR_W(ADDR_W)) u_buf (
    .clk        (clk),
    .rst        (rst),
    .we         (we),
    .waddr      (waddr),
    .wdata      (wdata),
    .commit_ptr (cp),
    .rd_ptr     (rp),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_sof    (out_sof),
    .out_eof    (out_eof)
  );
endmodule

// File: rtl/rx_frame_classifier_chk.sv
module rx_frame_classifier_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_dv,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       out_eof,
  input logic       pause_valid
);
  logic in_frame;

  always_ff @(posedge clk) begin
    if (rst) in_frame <= 1'b0;
    else if (out_valid) begin
      if (out_eof)      in_frame <= 1'b0;
      else if (out_sof) in_frame <= 1'b1;
    end
  end

  AST_TAG_CODE: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sof |-> out_data inside {[8'h01:8'h04]}); // R7
  AST_OPEN_WITH_SOF: assert property (@(posedge clk) disable iff (rst)
    out_valid && !in_frame |-> out_sof); // R8
  AST_STREAM_GAPLESS: assert property (@(posedge clk) disable iff (rst)
    in_frame |-> out_valid); // R11
  AST_NO_TINY_FRAME: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sof |-> !out_eof); // R6
  AST_PAUSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pause_valid |=> !pause_valid); // R9
  AST_PAUSE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    pause_valid |-> !$past(rx_dv)); // R9
endmodule

bind rx_frame_classifier rx_frame_classifier_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_dv       (rx_dv),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_sof     (out_sof),
  .out_eof     (out_eof),
  .pause_valid (pause_valid)
);

// File: tb/rx_frame_classifier_test.sv
`timescale 1ns/1ps
module rx_frame_classifier_test;
  localparam logic [47:0] LOCAL = 48'h0211_2233_4455;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] OTHER = 48'h0299_8877_6655;
  localparam logic [47:0] PDEST = 48'h0180_C200_0001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_dv = 1'b0;
  logic [7:0]  rx_d = 8'h00;
  logic        out_valid, out_sof, out_eof, pause_valid;
  logic [7:0]  out_data;
  logic [15:0] pause_quanta;

  always #2 clk = ~clk;

  rx_frame_classifier uut (
    .clk(clk), .rst(rst), .local_mac(LOCAL), .rx_dv(rx_dv), .rx_d(rx_d),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .pause_valid(pause_valid), .pause_quanta(pause_quanta)
  );

  int     total = 0, bad = 0, got_frames = 0, got_pause = 0;
  longint cyc = 0, end_cyc = 0;
  bit     lat_arm = 1'b0;
  logic [7:0]  fr[$];
  logic [9:0]  expq[$];
  logic [15:0] expp[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference monitor, compared on every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (expq.size() == 0) chk(1'b0, "R8", "unexpected output byte", {out_sof, out_eof, out_data}, 0);
        else begin
          logic [9:0] e;
          e = expq.pop_front();
          chk({out_sof, out_eof, out_data} == e, "R8", "output byte", {out_sof, out_eof, out_data}, e);
        end
        if (out_eof) got_frames++;
        if (out_sof && lat_arm) begin
          chk(cyc - end_cyc == 4, "R11", "start latency", cyc - end_cyc, 4);
          lat_arm = 1'b0;
        end
      end
      if (pause_valid) begin
        got_pause++;
        if (expp.size() == 0) chk(1'b0, "R9", "unexpected pause", pause_quanta, 0);
        else begin
          logic [15:0] p;
          p = expp.pop_front();
          chk(pause_quanta == p, "R9", "pause quanta", pause_quanta, p);
        end
        chk(cyc - end_cyc == 1, "R9", "pause latency", cyc - end_cyc, 1);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic build(input logic [47:0] da, input logic [15:0] et,
                       input logic [7:0] proto, input int len);
    fr.delete();
    for (int i = 0; i < 6; i++) fr.push_back(da[47-8*i -: 8]);
    for (int i = 0; i < 6; i++) fr.push_back(8'(8'h20 + i));
    fr.push_back(et[15:8]);
    fr.push_back(et[7:0]);
    for (int i = 14; i < len - 4; i++) fr.push_back(i == 23 ? proto : 8'(i * 7 + 3));
  endtask

  task automatic add_fcs(input bit corrupt);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    foreach (fr[k]) begin
      for (int b = 0; b < 8; b++) begin
        if (c[0] ^ fr[k][b]) c = (c >> 1) ^ 32'hEDB8_8320;
        else                 c = c >> 1;
      end
    end
    c = ~c;
    if (corrupt) c = c ^ 32'h0000_0100;
    for (int b = 0; b < 4; b++) fr.push_back(c[8*b +: 8]);
  endtask

  task automatic expect_frame(input logic [7:0] tag);
    int n;
    n = fr.size() - 4;
    expq.push_back({2'b10, tag});
    for (int i = 0; i < n; i++) expq.push_back({1'b0, i == n - 1, fr[i]});
  endtask

  task automatic send(input int gap, input bit bad_pre);
    repeat (gap) begin
      @(negedge clk);
      rx_dv <= 1'b0;
    end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rx_dv <= 1'b1;
      rx_d  <= (i == 7) ? 8'hD5 : ((bad_pre && i == 3) ? 8'h5A : 8'h55);
    end
    foreach (fr[k]) begin
      @(negedge clk);
      rx_d <= fr[k];
    end
    @(negedge clk);
    rx_dv   <= 1'b0;
    end_cyc = cyc;
  endtask

  task automatic run_case(input string req, input string what, input bit keep,
                          input logic [7:0] tag, input int gap, input bit bad_pre);
    int f0;
    f0 = got_frames;
    if (keep) expect_frame(tag);
    send(gap, bad_pre);
    idle(fr.size() + 40);
    chk(got_frames == f0 + int'(keep), req, what, got_frames - f0, int'(keep));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R11: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(4);
    chk(!out_valid && !pause_valid, "R1", "outputs in reset", {out_valid, pause_valid}, 0);
    rst <= 1'b0;
    idle(20);
    chk(!out_valid && !pause_valid, "R1", "outputs after reset", {out_valid, pause_valid}, 0);

    // R7/R5/R11: ARP to broadcast, latency measured
    build(BCAST, 16'h0806, 8'h00, 64); add_fcs(0);
    lat_arm = 1'b1;
    run_case("R7", "ARP broadcast kept", 1, 8'h03, 12, 0);
    build(LOCAL, 16'h0800, 8'd6, 100);  add_fcs(0); run_case("R7", "TCP kept", 1, 8'h01, 12, 0);
    build(LOCAL, 16'h0800, 8'd17, 200); add_fcs(0); run_case("R7", "UDP kept", 1, 8'h02, 12, 0);
    build(BCAST, 16'h0800, 8'd1, 80);   add_fcs(0); run_case("R7", "ICMP kept", 1, 8'h04, 12, 0);
    build(LOCAL, 16'h0800, 8'd2, 90);   add_fcs(0); run_case("R7", "other IP protocol dropped", 0, 0, 12, 0);
    build(LOCAL, 16'h86DD, 8'd6, 90);   add_fcs(0); run_case("R7", "other type dropped", 0, 0, 12, 0);

    // R4: bad FCS
    build(LOCAL, 16'h0800, 8'd6, 70);   add_fcs(1); run_case("R4", "bad FCS dropped", 0, 0, 12, 0);
    // R5: foreign destination
    build(OTHER, 16'h0800, 8'd17, 70);  add_fcs(0); run_case("R5", "foreign address dropped", 0, 0, 12, 0);
    // R6: length limits
    build(LOCAL, 16'h0800, 8'd6, 63);   add_fcs(0); run_case("R6", "runt dropped", 0, 0, 12, 0);
    build(LOCAL, 16'h0800, 8'd6, 1518); add_fcs(0); run_case("R6", "max length kept", 1, 8'h01, 12, 0);
    build(LOCAL, 16'h0800, 8'd6, 1519); add_fcs(0); run_case("R6", "oversize dropped", 0, 0, 12, 0);
    // R3: broken preamble
    build(LOCAL, 16'h0800, 8'd6, 64);   add_fcs(0); run_case("R3", "bad preamble dropped", 0, 0, 12, 1);

    // R2: short gap
    begin
      int f0;
      f0 = got_frames;
      build(LOCAL, 16'h0806, 8'h00, 64); add_fcs(0); expect_frame(8'h03);
      send(12, 0);
      build(LOCAL, 16'h0800, 8'd6, 64);  add_fcs(0);
      send(5, 0);
      idle(120);
      chk(got_frames == f0 + 1, "R2", "short gap frame dropped", got_frames - f0, 1);
    end
    build(LOCAL, 16'h0800, 8'd6, 64); add_fcs(0); run_case("R2", "full gap kept", 1, 8'h01, 12, 0);

    // R9: pause frames
    begin
      int p0, f0;
      p0 = got_pause; f0 = got_frames;
      build(PDEST, 16'h8808, 8'h00, 64); fr[14] = 8'h00; fr[15] = 8'h01; fr[16] = 8'hAB; fr[17] = 8'hCD;
      add_fcs(0); expp.push_back(16'hABCD);
      send(12, 0); idle(100);
      chk(got_pause == p0 + 1, "R9", "pause reported", got_pause - p0, 1);
      chk(got_frames == f0, "R9", "pause not stored", got_frames - f0, 0);
      build(PDEST, 16'h8808, 8'h00, 64); fr[14] = 8'h00; fr[15] = 8'h01; fr[16] = 8'h12; fr[17] = 8'h34;
      add_fcs(1);
      send(12, 0); idle(100);
      chk(got_pause == p0 + 1, "R9", "bad FCS pause ignored", got_pause - p0, 1);
      build(OTHER, 16'h8808, 8'h00, 64); fr[14] = 8'h00; fr[15] = 8'h01;
      add_fcs(0);
      send(12, 0); idle(100);
      chk(got_pause == p0 + 1, "R9", "foreign pause ignored", got_pause - p0, 1);
    end

    // R10: no room for a full frame at the start delimiter
    begin
      int f0;
      f0 = got_frames;
      build(LOCAL, 16'h0800, 8'd6, 1518); add_fcs(0); expect_frame(8'h01);
      send(12, 0);
      build(LOCAL, 16'h0800, 8'd17, 64);  add_fcs(0);
      send(11, 0);
      idle(1700);
      chk(got_frames == f0 + 1, "R10", "frame without room dropped", got_frames - f0, 1);
    end
    build(LOCAL, 16'h0800, 8'd17, 64); add_fcs(0); run_case("R10", "later frame kept", 1, 8'h02, 12, 0);

    chk(expq.size() == 0, "R8", "all expected bytes delivered", expq.size(), 0);
    chk(expp.size() == 0, "R9", "all expected pauses seen", expp.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule